// File: doc/BRIEF.md
# Four-Link Round-Robin Merger with Pause and Filler Drop

This block collects four independent 120-bit receive streams and merges them into one output stream. Each link writes into a private input FIFO. An arbiter visits the four input FIFOs in rotating order and moves at most one word per cycle into a deeper output FIFO. A downstream sink drains that FIFO through a show-ahead read port.

The block has no ready/valid backpressure toward the links. Flow control works in two ways. When the output FIFO fills past a high-water mark, the block enters a paused state and emits a one-cycle pause command, which the far side is expected to honour. While paused, any link word whose 120 bits are all zero is treated as filler and discarded before it reaches an input FIFO. When the output level falls back to a lower safe mark, the block leaves the paused state and emits a one-cycle resume command. Any word lost because its input FIFO was full sets a sticky overflow flag.

Top module: `linkMerger`

## Requirements
- R1: After reset all FIFOs are empty: `outValid`=0, `outLevel`=0, `paused`=0, `pauseCmd`=0, `resumeCmd`=0 and `overflow`=0.
- R2: Words from any one link reach `outData` unchanged and in the order that link presented them. A link word is captured on a rising edge where its bit of `linkValid` is 1, and link `i` occupies `linkData[i*DATA_W +: DATA_W]`.
- R3: The arbiter moves at most one word per cycle. After it serves link `i`, its search for the next word starts at link `(i+1) mod 4` and skips empty input FIFOs with no idle cycle. After reset the search starts at link 0.
- R4: `outLevel` equals the number of words held in the output FIFO, and `outValid` is 1 exactly when that number is nonzero. Holding `sinkRead` high for one edge while `outValid` is 1 removes the word shown on `outData`.
- R5: If `paused` is 0 and the clock edge sees `outLevel` >= `AFULL_LVL`, then after that edge `paused` is 1 and `pauseCmd` is 1 for exactly one cycle.
- R6: If `paused` is 1 and the clock edge sees `outLevel` <= `SAFE_LVL`, then after that edge `paused` is 0 and `resumeCmd` is 1 for exactly one cycle.
- R7: While `paused` is 1, a link word whose value is all zeros is discarded and never appears at the output. Nonzero words are still stored. While not paused, zero words are stored like any other word.
- R8: The output FIFO never takes a write when it holds `OUT_DEPTH` words. The merger then stalls, and words wait in the input FIFOs without loss or reordering.
- R9: Each input FIFO holds `IN_DEPTH` words. A word that arrives while its FIFO is full and is not discarded as filler is lost, and `overflow` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| linkValid | input | 4 | Per-link word strobe |
| linkData | input | 4*DATA_W | Link words, link i in slice i |
| sinkRead | input | 1 | Pop the head of the output FIFO |
| outData | output | DATA_W | Head word of the output FIFO |
| outValid | output | 1 | Output FIFO not empty |
| outLevel | output | $clog2(OUT_DEPTH)+1 | Output FIFO occupancy |
| paused | output | 1 | Paused state (filler drop active) |
| pauseCmd | output | 1 | One-cycle pause request toward the source |
| resumeCmd | output | 1 | One-cycle resume request toward the source |
| overflow | output | 1 | Sticky: a link word was lost |

## Verification
A rotation pointer left in the wrong state changes the order of merged words at once, on the next contested grant, and `outData` shows it when those words are popped. A wrong occupancy count appears on `outLevel` in the same cycle. It also moves the edge on which `paused` toggles, which the bench checks to the exact cycle on both the high mark and the safe mark. A filler check that is inverted or ignored changes `outLevel` within one cycle of the zero word, and an input FIFO that holds the wrong number of words moves the cycle in which `overflow` rises.

// File: rtl/lmPkg.sv
`timescale 1ns/1ps
package lmPkg;
  localparam int LINKS = 4;
  localparam int LINK_SEL_W = $clog2(LINKS);

  typedef struct packed {
    logic [LINKS-1:0] popSel;
    logic             pushOut;
    logic             paused;
  } lmStrobes_t;
endpackage

// File: rtl/lmFifo.sv
`timescale 1ns/1ps
module lmFifo #(
  parameter int W     = 120,
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [W-1:0]               wrData,
  input  logic                       rdEn,
  output logic [W-1:0]               rdData,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doWr, doRd;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= wrPtr + AW'(1);
      if (doRd) rdPtr <= rdPtr + AW'(1);
      case ({doWr, doRd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R8 / R9: a full FIFO with no read stays full, so a write never lands
  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (full && !rdEn) |=> full);
endmodule

// File: rtl/lmDatapath.sv
`timescale 1ns/1ps
module lmDatapath
  import lmPkg::*;
#(
  parameter int DATA_W    = 120,
  parameter int IN_DEPTH  = 1024,
  parameter int OUT_DEPTH = 4096
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [LINKS-1:0]              linkValid,
  input  logic [LINKS*DATA_W-1:0]       linkData,
  input  lmStrobes_t                    strobes,
  input  logic                          sinkRead,
  output logic [LINKS-1:0]              inEmpty,
  output logic [$clog2(OUT_DEPTH):0]    outCount,
  output logic                          outFull,
  output logic [DATA_W-1:0]             outData,
  output logic                          outValid,
  output logic                          overflow
);
  localparam int ICW = $clog2(IN_DEPTH) + 1;

  logic [DATA_W-1:0] inData  [LINKS];
  logic [ICW-1:0]    inCount [LINKS];
  logic [LINKS-1:0]  inFull;
  logic [LINKS-1:0]  keepWord;
  logic [LINKS-1:0]  lostWord;
  logic [DATA_W-1:0] selData;
  logic              outEmpty;

  for (genvar g = 0; g < LINKS; g++) begin : gLink
    logic [DATA_W-1:0] word;
    assign word        = linkData[g*DATA_W +: DATA_W];
    assign keepWord[g] = linkValid[g] && !(strobes.paused && (word == '0));
    assign lostWord[g] = keepWord[g] && inFull[g];

    lmFifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_inFifo (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (keepWord[g]),
      .wrData (word),
      .rdEn   (strobes.popSel[g]),
      .rdData (inData[g]),
      .empty  (inEmpty[g]),
      .full   (inFull[g]),
      .count  (inCount[g])
    );

    // R7: a zero word offered while paused must not grow its input FIFO
    assert_filler_dropped_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.paused && linkValid[g] && (word == '0) && !strobes.popSel[g])
        |=> (inCount[g] == $past(inCount[g])));
  end

  always_comb begin
    selData = '0;
    for (int i = 0; i < LINKS; i++) begin
      if (strobes.popSel[i]) selData = inData[i];
    end
  end

  lmFifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_outFifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strobes.pushOut),
    .wrData (selData),
    .rdEn   (sinkRead),
    .rdData (outData),
    .empty  (outEmpty),
    .full   (outFull),
    .count  (outCount)
  );

  assign outValid = !outEmpty;

  always_ff @(posedge clk) begin
    if (!rstN)          overflow <= 1'b0;
    else if (|lostWord) overflow <= 1'b1;
  end

  // R9: the loss flag is sticky until reset
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
endmodule

// File: rtl/lmControl.sv
`timescale 1ns/1ps
module lmControl
  import lmPkg::*;
#(
  parameter int OUT_DEPTH = 4096,
  parameter int AFULL_LVL = 3584,
  parameter int SAFE_LVL  = 2048
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [LINKS-1:0]              inEmpty,
  input  logic [$clog2(OUT_DEPTH):0]    outCount,
  input  logic                          outFull,
  output lmStrobes_t                    strobes,
  output logic                          pauseCmd,
  output logic                          resumeCmd
);
  localparam int OCW = $clog2(OUT_DEPTH) + 1;

  logic [LINK_SEL_W-1:0] rrPtr;
  logic [LINK_SEL_W-1:0] grantIdx;
  logic                  grantAny;
  logic                  pausedQ;
  logic                  enterPause, leavePause;

  always_comb begin
    grantAny = 1'b0;
    grantIdx = '0;
    for (int off = 0; off < LINKS; off++) begin
      logic [LINK_SEL_W-1:0] cand;
      cand = rrPtr + LINK_SEL_W'(off);
      if (!grantAny && !inEmpty[cand]) begin
        grantAny = 1'b1;
        grantIdx = cand;
      end
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.pushOut = grantAny && !outFull;
    strobes.paused  = pausedQ;
    if (strobes.pushOut) strobes.popSel[grantIdx] = 1'b1;
  end

  assign enterPause = !pausedQ && (outCount >= OCW'(AFULL_LVL));
  assign leavePause =  pausedQ && (outCount <= OCW'(SAFE_LVL));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr     <= '0;
      pausedQ   <= 1'b0;
      pauseCmd  <= 1'b0;
      resumeCmd <= 1'b0;
    end else begin
      if (strobes.pushOut) rrPtr <= grantIdx + LINK_SEL_W'(1);
      if (enterPause)      pausedQ <= 1'b1;
      else if (leavePause) pausedQ <= 1'b0;
      pauseCmd  <= enterPause;
      resumeCmd <= leavePause;
    end
  end

  // R3: never more than one input FIFO popped per cycle
  assert_one_pop_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.popSel));
  // R8: no push toward a full output FIFO
  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushOut |-> !outFull);
  // R5: pause only after the high mark was seen
  assert_pause_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pausedQ) |-> ($past(outCount) >= OCW'(AFULL_LVL)));
  // R6: resume only after the safe mark was seen
  assert_resume_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pausedQ) |-> ($past(outCount) <= OCW'(SAFE_LVL)));
endmodule

// File: rtl/linkMerger.sv
`timescale 1ns/1ps
module linkMerger
  import lmPkg::*;
#(
  parameter int DATA_W    = 120,
  parameter int IN_DEPTH  = 1024,
  parameter int OUT_DEPTH = 4096,
  parameter int AFULL_LVL = 3584,
  parameter int SAFE_LVL  = 2048
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [3:0]                    linkValid,
  input  logic [4*DATA_W-1:0]           linkData,
  input  logic                          sinkRead,
  output logic [DATA_W-1:0]             outData,
  output logic                          outValid,
  output logic [$clog2(OUT_DEPTH):0]    outLevel,
  output logic                          paused,
  output logic                          pauseCmd,
  output logic                          resumeCmd,
  output logic                          overflow
);
  lmStrobes_t       strobes;
  logic [LINKS-1:0] inEmpty;
  logic             outFull;

  lmDatapath #(.DATA_W(DATA_W), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .linkValid (linkValid),
    .linkData  (linkData),
    .strobes   (strobes),
    .sinkRead  (sinkRead),
    .inEmpty   (inEmpty),
    .outCount  (outLevel),
    .outFull   (outFull),
    .outData   (outData),
    .outValid  (outValid),
    .overflow  (overflow)
  );

  lmControl #(.OUT_DEPTH(OUT_DEPTH), .AFULL_LVL(AFULL_LVL), .SAFE_LVL(SAFE_LVL)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .inEmpty   (inEmpty),
    .outCount  (outLevel),
    .outFull   (outFull),
    .strobes   (strobes),
    .pauseCmd  (pauseCmd),
    .resumeCmd (resumeCmd)
  );

  assign paused = strobes.paused;
endmodule

// File: tb/linkMerger_bench.sv
`timescale 1ns/1ps
module linkMerger_bench;
  localparam int DW = 120;
  localparam int IND = 4;
  localparam int OUTD = 16;
  localparam int AF = 12;
  localparam int SF = 4;
  localparam int LW = $clog2(OUTD) + 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [3:0]      linkValid = '0;
  logic [4*DW-1:0] linkData = '0;
  logic            sinkRead = 1'b0;
  logic [DW-1:0]   outData;
  logic            outValid;
  logic [LW-1:0]   outLevel;
  logic            paused, pauseCmd, resumeCmd, overflow;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  linkMerger #(.DATA_W(DW), .IN_DEPTH(IND), .OUT_DEPTH(OUTD),
               .AFULL_LVL(AF), .SAFE_LVL(SF)) u_linkMerger (
    .clk(clk), .rstN(rstN), .linkValid(linkValid), .linkData(linkData),
    .sinkRead(sinkRead), .outData(outData), .outValid(outValid),
    .outLevel(outLevel), .paused(paused), .pauseCmd(pauseCmd),
    .resumeCmd(resumeCmd), .overflow(overflow));

  function automatic logic [DW-1:0] mk(int l, int k);
    return DW'((l + 1) * 256 + k + 1);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic popCheck(string tag, logic [DW-1:0] exp);
    tick();
    check({tag, " valid"}, DW'(outValid), DW'(1));
    check(tag, outData, exp);
    sinkRead = 1'b1;
    tick();
    sinkRead = 1'b0;
  endtask

  task automatic setLink(int l, logic [DW-1:0] w);
    linkData[l*DW +: DW] = w;
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1: reset state
    check("R1 outValid", DW'(outValid), '0);
    check("R1 outLevel", DW'(outLevel), '0);
    check("R1 paused", DW'(paused), '0);
    check("R1 pauseCmd", DW'(pauseCmd), '0);
    check("R1 resumeCmd", DW'(resumeCmd), '0);
    check("R1 overflow", DW'(overflow), '0);

    // R2/R4: single link, three words
    for (int k = 0; k < 3; k++) begin
      linkValid = 4'b0100; setLink(2, mk(2, k)); tick();
    end
    linkValid = '0;
    repeat (4) tick();
    check("R4 level3", DW'(outLevel), DW'(3));
    for (int k = 0; k < 3; k++) popCheck("R2 single link", mk(2, k));
    tick();
    check("R4 empty", DW'(outValid), '0);

    // R3: all four links contend; rotation starts at link 3 after link 2 was served
    for (int k = 0; k < 2; k++) begin
      linkValid = 4'hF;
      for (int l = 0; l < 4; l++) setLink(l, mk(l, k));
      tick();
    end
    linkValid = '0;
    repeat (10) tick();
    check("R4 level8", DW'(outLevel), DW'(8));
    for (int n = 0; n < 8; n++) popCheck("R3 rotation", mk((3 + n) % 4, n / 4));

    // R3: empty links skipped with no idle cycle (start at link 3)
    linkValid = 4'b1010; setLink(1, mk(1, 0)); setLink(3, mk(3, 0)); tick();
    setLink(1, mk(1, 1)); setLink(3, mk(3, 1)); tick();
    linkValid = '0; tick(); tick();
    check("R3 no idle level3", DW'(outLevel), DW'(3));
    tick();
    check("R3 no idle level4", DW'(outLevel), DW'(4));
    popCheck("R3 skip", mk(3, 0));
    popCheck("R3 skip", mk(1, 0));
    popCheck("R3 skip", mk(3, 1));
    popCheck("R3 skip", mk(1, 1));

    // R7: zero word stored while not paused
    linkValid = 4'b1000; setLink(3, '0); tick();
    linkValid = '0; repeat (3) tick();
    check("R7 zero kept level", DW'(outLevel), DW'(1));
    popCheck("R7 zero kept", '0);

    // R5: fill to the high mark from link 0
    for (int k = 0; k < 12; k++) begin
      linkValid = 4'b0001; setLink(0, mk(0, k)); tick();
    end
    linkValid = '0;
    tick();
    check("R5 level12", DW'(outLevel), DW'(12));
    check("R5 not yet paused", DW'(paused), '0);
    tick();
    check("R5 paused", DW'(paused), DW'(1));
    check("R5 pauseCmd pulse", DW'(pauseCmd), DW'(1));
    tick();
    check("R5 pauseCmd one cycle", DW'(pauseCmd), '0);
    check("R5 still paused", DW'(paused), DW'(1));

    // R7: filler dropped while paused, nonzero kept
    linkValid = 4'b0111; setLink(0, '0); setLink(1, '0); setLink(2, mk(2, 7)); tick();
    linkValid = 4'b0010; tick();
    linkValid = '0; repeat (3) tick();
    check("R7 filler dropped level", DW'(outLevel), DW'(13));

    // R6: drain continuously down to the safe mark
    sinkRead = 1'b1;
    repeat (9) tick();
    check("R6 level4", DW'(outLevel), DW'(4));
    check("R6 still paused", DW'(paused), DW'(1));
    tick();
    check("R6 resumed", DW'(paused), '0);
    check("R6 resumeCmd pulse", DW'(resumeCmd), DW'(1));
    sinkRead = 1'b0;
    tick();
    check("R6 resumeCmd one cycle", DW'(resumeCmd), '0);
    popCheck("R2 after drain", mk(0, 10));
    popCheck("R2 after drain", mk(0, 11));
    popCheck("R7 nonzero kept while paused", mk(2, 7));
    tick();
    check("R4 empty after drain", DW'(outValid), '0);

    // R8/R9: saturate output and input FIFOs
    for (int k = 0; k < 22; k++) begin
      linkValid = 4'b0001; setLink(0, mk(0, k)); tick();
      if (k == 19) check("R9 no loss yet", DW'(overflow), '0);
      if (k == 20) check("R9 loss flagged", DW'(overflow), DW'(1));
    end
    linkValid = '0;
    repeat (3) tick();
    check("R8 capped level", DW'(outLevel), DW'(16));
    check("R8 paused while full", DW'(paused), DW'(1));
    for (int k = 0; k < 20; k++) popCheck("R8 order kept", mk(0, k));
    tick();
    check("R8 all drained", DW'(outValid), '0);
    check("R9 sticky", DW'(overflow), DW'(1));

    rstN = 1'b0; tick(); tick();
    rstN = 1'b1; tick();
    check("R1 overflow cleared", DW'(overflow), '0);
    check("R1 paused cleared", DW'(paused), '0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end
endmodule